// File: doc/BRIEF.md
# Prescaled Periodic Timer Array

This block produces periodic time-out events on four independent channels. Two shared 8-bit prescaler down-counters run on the bus clock. Each prescaler emits one tick whenever it passes through zero and then reloads. Every channel owns a 16-bit down-counter. It steps once per tick of the prescaler that its select bit picks. When the channel counter is at zero and a tick arrives, the channel does three things in one cycle: it reloads from its own load value, sets a sticky time-out flag, and pulses its trigger output for one clock. The spacing between time-outs is therefore (prescaler load + 1) × (channel load + 1) bus clocks.

Software controls the block through a flat 16-bit write port and a combinational read port. One address restarts prescalers and channels. The prescaler restart bits sit in the byte directly above the channel restart bits, so a single write can restart any mix of them together. Time-out flags are cleared by writing ones to them. Each channel has an interrupt enable, and its interrupt request is the flag gated by that enable. A global run bit stops all counting. A freeze bit makes counting halt while the debug-halt input is high.

Top module: `periodic_timer`

## Requirements
- R1: After the edge that starts counting from freshly restarted counters, the first trigger of a channel appears after exactly (P+1)×(C+1) clock edges, and each later trigger follows the previous one by the same count. P is the selected prescaler load and C is the channel load.
- R2: Config bit 8+i selects the prescaler for channel i: 0 picks prescaler 0 and 1 picks prescaler 1. The load of the unselected prescaler has no effect on that channel's period.
- R3: A channel time-out sets flag bit i, readable at address 3 bits [3:0], in the same cycle as its trigger pulse. The flag stays set after the trigger ends.
- R4: Writing address 3 clears exactly those flag bits written as one. Bits written as zero leave their flags unchanged.
- R5: irq[i] is high exactly when flag i is set and bit i of the interrupt-enable register (address 2) is set.
- R6: trig[i] is high for a single clock per time-out whenever the period is longer than one clock, whatever the interrupt enable holds.
- R7: Prescaler m takes its load from address 4+m (8 bits). Channel i takes its load from address 8+i. Channel i's current count reads at address 12+i.
- R8: At address 0, a write restarts channel i when bit i is one and prescaler m when bit 8+m is one, all in the same edge. The address reads as zero, and a restart never sets a flag.
- R9: Config bit 0 (address 1) is the run bit. While it is clear, channel counts hold and no trigger occurs.
- R10: With config bit 1 set, counting holds while dbg_halt is high and resumes when it falls. With bit 1 clear, dbg_halt has no effect.
- R11: A flag-clear write landing in the same edge as that channel's time-out leaves the flag set.
- R12: After reset, config, flags, enables, loads and counts read zero, and trig and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt | input | 1 | Debug halt indication, honoured when the freeze bit is set |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| trig | output | 4 | One-clock time-out pulse per channel |
| irq | output | 4 | Per-channel interrupt request |

## Verification
A flag-clear write and a time-out of the same channel can land on one clock edge. The timeout sets the flag and the write tries to drop it. The bench restarts a channel with small loads, computes the time-out edge from (P+1)×(C+1), and times the clear write to hit exactly that edge. It then reads the flag and expects it to be set. A second clear, one cycle later and away from any time-out, must leave the flag clear, which shows the earlier result came from the collision and not from a write that did nothing. The same timing method is applied to restart writes issued while the counters are running.

// File: rtl/periodic_timer_pkg.sv
`timescale 1ns/1ps
package periodic_timer_pkg;
  // register addresses
  localparam int unsigned A_RESTART = 0;
  localparam int unsigned A_CONFIG  = 1;
  localparam int unsigned A_IRQEN   = 2;
  localparam int unsigned A_FLAGS   = 3;
  localparam int unsigned A_PRELOAD = 4;
  localparam int unsigned A_CHLOAD  = 8;
  localparam int unsigned A_CHCOUNT = 12;

  // bit positions
  localparam int unsigned CFG_RUN_BIT = 0;
  localparam int unsigned CFG_FRZ_BIT = 1;
  localparam int unsigned CFG_SEL_LSB = 8;
  localparam int unsigned PRE_FL_LSB  = 8;

  // bus clocks between time-outs for given load values
  function automatic int unsigned timeout_cycles(input int unsigned pre_ld,
                                                 input int unsigned ch_ld);
    return (pre_ld + 1) * (ch_ld + 1);
  endfunction
endpackage

// File: rtl/ptmr_prescaler.sv
`timescale 1ns/1ps
module ptmr_prescaler #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          force_ld,
  input  logic [PW-1:0] load,
  output logic          tick
);
  logic [PW-1:0] cnt;

  function automatic logic [PW-1:0] next_val(input logic [PW-1:0] cur,
                                             input logic [PW-1:0] ld);
    return (cur == '0) ? ld : cur - 1'b1;
  endfunction

  // a restart in the same cycle swallows the tick
  assign tick = run && !force_ld && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (force_ld) cnt <= load;
    else if (run)      cnt <= next_val(cnt, load);
  end
endmodule

// File: rtl/ptmr_channel.sv
`timescale 1ns/1ps
module ptmr_channel #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          force_ld,
  input  logic [CW-1:0] load,
  output logic [CW-1:0] count,
  output logic          expire
);
  function automatic logic [CW-1:0] next_val(input logic [CW-1:0] cur,
                                             input logic [CW-1:0] ld);
    return (cur == '0) ? ld : cur - 1'b1;
  endfunction

  assign expire = step && !force_ld && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (force_ld) count <= load;
    else if (step)     count <= next_val(count, load);
  end
endmodule

// File: rtl/periodic_timer.sv
`timescale 1ns/1ps
module periodic_timer
  import periodic_timer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned N_PRE  = 2,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_halt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_CH-1:0]   trig,
  output logic [N_CH-1:0]   irq
);
  localparam int unsigned SEL_W = (N_PRE > 1) ? $clog2(N_PRE) : 1;

  logic                              cfg_run, cfg_frz;
  logic [N_CH-1:0][SEL_W-1:0]        cfg_sel;
  logic [N_CH-1:0]                   irq_en, flag_q;
  logic [N_CH-1:0]                   ch_force, ch_step, ch_expire;
  logic [N_PRE-1:0]                  pre_force, pre_tick;
  logic [N_PRE-1:0][PRE_W-1:0]       pre_load;
  logic [N_CH-1:0][CNT_W-1:0]        ch_load, ch_cnt;
  logic                              run_en;
  logic                              wr_restart, wr_config, wr_irqen, wr_flags;
  logic [N_CH-1:0]                   clr_mask;

  assign wr_restart = wr_en && (addr == ADDR_W'(A_RESTART));
  assign wr_config  = wr_en && (addr == ADDR_W'(A_CONFIG));
  assign wr_irqen   = wr_en && (addr == ADDR_W'(A_IRQEN));
  assign wr_flags   = wr_en && (addr == ADDR_W'(A_FLAGS));
  assign clr_mask   = wr_flags ? wdata[N_CH-1:0] : '0;

  assign run_en = cfg_run && !(cfg_frz && dbg_halt);

  generate
    for (genvar m = 0; m < N_PRE; m++) begin : g_pre
      assign pre_force[m] = wr_restart && wdata[PRE_FL_LSB + m];
      ptmr_prescaler #(.PW(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_en), .force_ld(pre_force[m]),
        .load(pre_load[m]), .tick(pre_tick[m])
      );
    end
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      assign ch_force[i] = wr_restart && wdata[i];
      assign ch_step[i]  = pre_tick[cfg_sel[i]];
      ptmr_channel #(.CW(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .step(ch_step[i]), .force_ld(ch_force[i]),
        .load(ch_load[i]), .count(ch_cnt[i]), .expire(ch_expire[i])
      );
    end
  endgenerate

  // control and load registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_run  <= 1'b0;
      cfg_frz  <= 1'b0;
      cfg_sel  <= '0;
      irq_en   <= '0;
      pre_load <= '0;
      ch_load  <= '0;
    end else begin
      if (wr_config) begin
        cfg_run <= wdata[CFG_RUN_BIT];
        cfg_frz <= wdata[CFG_FRZ_BIT];
        for (int i = 0; i < N_CH; i++)
          cfg_sel[i] <= wdata[CFG_SEL_LSB + i*SEL_W +: SEL_W];
      end
      if (wr_irqen) irq_en <= wdata[N_CH-1:0];
      for (int m = 0; m < N_PRE; m++)
        if (wr_en && addr == ADDR_W'(A_PRELOAD + m)) pre_load[m] <= wdata[PRE_W-1:0];
      for (int i = 0; i < N_CH; i++)
        if (wr_en && addr == ADDR_W'(A_CHLOAD + i)) ch_load[i] <= wdata[CNT_W-1:0];
    end
  end

  // sticky flags: a set from a time-out wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      trig   <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_mask) | ch_expire;
      trig   <= ch_expire;
    end
  end

  assign irq = flag_q & irq_en;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CONFIG)) begin
      rdata[CFG_RUN_BIT] = cfg_run;
      rdata[CFG_FRZ_BIT] = cfg_frz;
      for (int i = 0; i < N_CH; i++)
        rdata[CFG_SEL_LSB + i*SEL_W +: SEL_W] = cfg_sel[i];
    end
    if (addr == ADDR_W'(A_IRQEN)) rdata[N_CH-1:0] = irq_en;
    if (addr == ADDR_W'(A_FLAGS)) rdata[N_CH-1:0] = flag_q;
    for (int m = 0; m < N_PRE; m++)
      if (addr == ADDR_W'(A_PRELOAD + m)) rdata = DATA_W'(pre_load[m]);
    for (int i = 0; i < N_CH; i++) begin
      if (addr == ADDR_W'(A_CHLOAD + i))  rdata = DATA_W'(ch_load[i]);
      if (addr == ADDR_W'(A_CHCOUNT + i)) rdata = DATA_W'(ch_cnt[i]);
    end
  end
endmodule

// File: rtl/periodic_timer_chk.sv
`timescale 1ns/1ps
module periodic_timer_chk
  import periodic_timer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wdata,
  input logic [N_CH-1:0]            trig,
  input logic [N_CH-1:0]            irq,
  input logic [N_CH-1:0]            flag_q,
  input logic                       run_en,
  input logic [N_CH-1:0][CNT_W-1:0] ch_cnt
);
  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      // R3
      trig_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig[i] |-> flag_q[i]);
      // R3
      flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[i]) |-> trig[i]);
      // R4
      flag_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[i]) |-> $past(wr_en && addr == ADDR_W'(A_FLAGS) && wdata[i]));
      // R5
      irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[i] |-> flag_q[i]);
    end
  endgenerate

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !(wr_en && addr == ADDR_W'(A_RESTART))) |=> $stable(ch_cnt));
endmodule

bind periodic_timer periodic_timer_chk #(
  .N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .trig(trig), .irq(irq), .flag_q(flag_q), .run_en(run_en), .ch_cnt(ch_cnt)
);

// File: tb/test_periodic_timer.sv
`timescale 1ns/1ps
module test_periodic_timer;
  localparam int A_RST = 0, A_CFG = 1, A_IEN = 2, A_FLG = 3, A_PRE = 4, A_CHL = 8, A_CNT = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  trig, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  periodic_timer i_periodic_timer (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .trig(trig), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    addr = a[3:0]; wdata = d[15:0]; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = a[3:0];
    #1;
    v = int'(rdata);
  endtask

  task automatic sweep_one(input int pre, input int ch, input int pl, input int cl);
    int n, v, c1, c2;
    n = (pl + 1) * (cl + 1);
    wr(A_CFG, 0);
    wr(A_IEN, 0);
    wr(A_PRE + pre, pl);
    wr(A_PRE + (1 - pre), pl + 2);   // R2: unselected prescaler differs
    wr(A_CHL + ch, cl);
    wr(A_RST, (1 << ch) | (1 << (8 + pre)));
    wr(A_FLG, 'hF);
    rd(A_RST, v);      chk("R8 restart reads zero", v, 0);
    rd(A_CNT + ch, v); chk("R7 count after restart", v, cl);
    rd(A_FLG, v);      chk("R8 restart sets no flag", (v >> ch) & 1, 0);
    wr(A_CFG, 1 | (pre << (8 + ch)));  // counting starts at this edge
    step(n - 1);
    chk("R1 no early trigger", int'(trig[ch]), 0);
    rd(A_CNT + ch, v); chk("R7 count at zero before timeout", v, 0);
    step(1);
    chk("R1/R2 first period trigger", int'(trig[ch]), 1);
    rd(A_FLG, v); chk("R3 flag set with trigger", (v >> ch) & 1, 1);
    chk("R6 trigger while irq disabled, R5 irq low", int'(irq[ch]), 0);
    step(1);
    chk("R6 single-cycle trigger", int'(trig[ch]), (n > 1) ? 0 : 1);
    step(n - 1);
    chk("R1 second period trigger", int'(trig[ch]), 1);
    wr(A_IEN, 1 << ch);
    chk("R5 irq with flag and enable", int'(irq[ch]), 1);
    wr(A_FLG, 0);
    rd(A_FLG, v); chk("R4 zero write keeps flag", (v >> ch) & 1, 1);
    wr(A_CFG, 0);
    wr(A_FLG, 1 << ch);
    rd(A_FLG, v); chk("R4 clear flag", (v >> ch) & 1, 0);
    chk("R5 irq drops with flag", int'(irq[ch]), 0);
    rd(A_CNT + ch, c1);
    step(7);
    rd(A_CNT + ch, c2);
    chk("R9 count holds while stopped", c2, c1);
    chk("R9 no trigger while stopped", int'(trig[ch]), 0);
  endtask

  initial begin
    int v, c1, c2, n;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R12 reset state
    chk("R12 trig low", int'(trig), 0);
    chk("R12 irq low", int'(irq), 0);
    rd(A_CFG, v); chk("R12 config zero", v, 0);
    rd(A_FLG, v); chk("R12 flags zero", v, 0);
    rd(A_IEN, v); chk("R12 enables zero", v, 0);
    for (int i = 0; i < 4; i++) begin
      rd(A_CNT + i, v); chk("R12 count zero", v, 0);
      rd(A_CHL + i, v); chk("R12 load zero", v, 0);
    end

    // R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep
    for (int pre = 0; pre < 2; pre++)
      for (int ch = 0; ch < 4; ch++)
        for (int pl = 0; pl < 4; pl++)
          for (int cl = 0; cl < 4; cl++)
            sweep_one(pre, ch, pl, cl);

    // R11 clear colliding with a time-out
    wr(A_CFG, 0);
    wr(A_PRE, 1); wr(A_CHL, 1);
    wr(A_RST, 'h101);
    wr(A_FLG, 'hF);
    n = (1 + 1) * (1 + 1);
    wr(A_CFG, 1);
    step(n - 1);
    wr(A_FLG, 1);                      // lands on the timeout edge
    rd(A_FLG, v); chk("R11 flag survives colliding clear", v & 1, 1);
    wr(A_FLG, 1);                      // away from any timeout
    rd(A_FLG, v); chk("R11 clear apart from timeout works", v & 1, 0);

    // R8 group restart while running, one write
    wr(A_CFG, 0);
    wr(A_PRE, 2); wr(A_PRE + 1, 1);
    wr(A_CHL, 1); wr(A_CHL + 1, 3);
    wr(A_CFG, 1 | (1 << 9));           // ch0 -> pre0, ch1 -> pre1
    step(5);
    wr(A_RST, 'h303);
    for (int k = 1; k <= 8; k++) begin
      step(1);
      chk("R8 group restart ch0 timing", int'(trig[0]), (k == 6) ? 1 : 0);
      chk("R8 group restart ch1 timing", int'(trig[1]), (k == 8) ? 1 : 0);
    end

    // R10 freeze during debug halt
    wr(A_CFG, 0);
    wr(A_PRE, 1); wr(A_CHL, 2);
    wr(A_RST, 'h101);
    dbg_halt = 1'b1;
    wr(A_CFG, 3);
    step(20);
    rd(A_CNT, v); chk("R10 frozen count holds", v, 2);
    chk("R10 no trigger while frozen", int'(trig[0]), 0);
    dbg_halt = 1'b0;
    step(3);
    rd(A_CNT, v); chk("R10 resumes after halt", v, 1);
    dbg_halt = 1'b1;
    wr(A_CFG, 1);
    rd(A_CNT, c1);
    step(4);
    rd(A_CNT, c2);
    chk("R10 halt ignored without freeze", int'(c1 != c2), 1);
    dbg_halt = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule